// File: doc/BRIEF.md
# Dithered 14-bit PWM Digital-to-Analog Timer

This block turns a 14-bit code into a pulse train whose average level, after an external low-pass filter, tracks the code. One conversion cycle lasts 16384 resolution steps. A step lasts from one `step_en` tick to the next. The conversion cycle is cut into short base cycles so that the ripple left after filtering stays at a high frequency.

Every base cycle carries a coarse basic pulse. The upper bits of the code set its width. The lower bits of the code choose some of the base cycles, and each chosen cycle gets one extra pulse one step wide. Over a full conversion cycle the active time, counted in steps, equals the code. The chosen cycles are spread evenly across the conversion cycle.

A mode bit selects between two base-cycle lengths: 256 steps or 64 steps. A polarity bit makes the active level low. The code, the mode and the polarity are sampled only at a conversion-cycle boundary. A one-clock strobe marks the first step of each new conversion cycle.

Top module: `dpwm_dac`

## Requirements
- R1: A conversion cycle lasts exactly 16384 steps. `conv_strobe` is high for one clock in the first clock of each conversion cycle after the first. It stays low through reset and through the first conversion cycle after reset.
- R2: The step position advances only on clocks where `step_en` is high. While `step_en` is low, `pwm_out` holds its value, so every step lasts as many clocks as the tick spacing.
- R3: With `long_base` = 1, a base cycle lasts 256 steps. The basic pulse is active for the first `dac_data[13:6]` steps of every base cycle, beginning at step 0.
- R4: With `long_base` = 0, a base cycle lasts 64 steps. The basic pulse is active for the first `dac_data[13:8]` steps of every base cycle.
- R5: Base cycle i gets one additional active step, placed right after its basic pulse, when the bit-reversed value of i is less than the additional field. The additional field is `dac_data[5:0]` with `long_base` = 1 (i is 6 bits) and `dac_data[7:0]` with `long_base` = 0 (i is 8 bits). Base cycle 0 therefore gets the extra step whenever the field is nonzero, and the last base cycle never gets it.
- R6: With `invert` = 0, the number of steps in a conversion cycle where `pwm_out` is high equals `dac_data`. This holds from 0 up to 16383.
- R7: With `invert` = 1, `pwm_out` is the complement of the non-inverted waveform, so it is low during active steps.
- R8: `dac_data`, `long_base` and `invert` are sampled only at the step that starts a conversion cycle. Changes at any other time do not affect the waveform of the cycle already running.
- R9: During reset and through the first conversion cycle after reset, the sampled code is 0 and the polarity is non-inverted. `pwm_out` is therefore low for that whole cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Resolution-step tick; advances the step position |
| dac_data | input | 14 | Code to convert |
| long_base | input | 1 | 1: base cycle of 256 steps; 0: base cycle of 64 steps |
| invert | input | 1 | 1: active level is low |
| pwm_out | output | 1 | PWM output |
| conv_strobe | output | 1 | One-clock pulse at the first step of a conversion cycle |

## Verification
A wrong step counter shows up at `conv_strobe` as a conversion period other than 16384 steps, one full conversion cycle later. It also shifts the base-cycle widths seen at `pwm_out` within the first base cycle. A wrong split of the code between the basic and additional fields leaves the total active time correct in some cases but not the width of base cycle 0 or of the last base cycle. The bench therefore measures those two widths separately, and they show the error inside one base cycle. A latch that updates in the middle of a cycle is caught because the bench always changes the inputs just after a strobe and expects the old code to hold until the next boundary.

// File: rtl/dpwm_pkg.sv
// Shared definitions for the dithered PWM D/A timer.
// Assumes: nothing beyond the standard language.
package dpwm_pkg;

    // Base-cycle length selection as seen by the shaping logic.
    typedef enum logic {
        MODE_SHORT_BASE = 1'b0,
        MODE_LONG_BASE  = 1'b1
    } base_mode_e;

endpackage

// File: rtl/dpwm_step_counter.sv
// Step position counter for one conversion cycle.
// Advances once per step tick and wraps after 2**CNT_W steps. It exposes
// the position it will hold after the coming edge, plus a wrap flag that is
// high in the clock whose edge returns the position to zero.
// Assumes: step_en is synchronous to clk.
module dpwm_step_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [CNT_W-1:0] cnt_next,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] LAST_STEP = '1;
    localparam logic [CNT_W-1:0] ONE       = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Next position and boundary detection.
    always_comb begin
        wrap     = step_en && (cnt_q == LAST_STEP);
        cnt_next = step_en ? cnt_q + ONE : cnt_q;
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/dpwm_data_latch.sv
// Boundary latch for the code, the mode and the polarity.
// Captures the inputs only when load is high and otherwise holds them. The
// value that will be in force after the coming edge is given combinationally.
// Assumes: load is high for one clock per conversion boundary.
module dpwm_data_latch #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              long_in,
    input  logic              inv_in,
    output logic [DATA_W-1:0] data_next,
    output logic              long_next,
    output logic              inv_next
);

    logic [DATA_W-1:0] data_q;
    logic              long_q;
    logic              inv_q;

    // Select between the held and the freshly sampled values.
    always_comb begin
        data_next = load ? data_in : data_q;
        long_next = load ? long_in : long_q;
        inv_next  = load ? inv_in  : inv_q;
    end

    // Held copies; reset to a zero code with non-inverted polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            long_q <= 1'b0;
            inv_q  <= 1'b0;
        end else begin
            data_q <= data_next;
            long_q <= long_next;
            inv_q  <= inv_next;
        end
    end

endmodule

// File: rtl/dpwm_slot_eval.sv
// Active-level decision for one base-cycle geometry.
// pos is the step inside the base cycle and idx is the base-cycle number.
// A step is active while pos is below basic. The step at pos == basic is
// also active when the bit-reversed idx is below add.
// Assumes: purely combinational; widths are chosen by the parent.
module dpwm_slot_eval #(
    parameter int POS_W = 8,
    parameter int IDX_W = 6
) (
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] basic,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] add,
    output logic             active
);

    logic [IDX_W-1:0] idx_rev;

    // Mirror the base-cycle number so extra steps spread evenly.
    for (genvar b = 0; b < IDX_W; b++) begin : g_rev
        assign idx_rev[b] = idx[IDX_W-1-b];
    end

    // Basic pulse, then at most one extra step.
    always_comb begin
        active = (pos < basic) || ((pos == basic) && (idx_rev < add));
    end

endmodule

// File: rtl/dpwm_dac.sv
// Dithered PWM digital-to-analog timer, top level.
// A step counter runs through one conversion cycle. A boundary latch holds
// the code for that cycle. Two slot evaluators, one per base-cycle length,
// decide the active level, and a registered output stage drives the pins.
// Every register on the output path is loaded from next-state values, so
// pwm_out and conv_strobe line up with the step position held in the counter.
// Assumes: DATA_W equals the counter width; LONG_POS_W and SHORT_POS_W are
// both below DATA_W.
module dpwm_dac
    import dpwm_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int LONG_POS_W  = 8,
    parameter int SHORT_POS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [DATA_W-1:0] dac_data,
    input  logic              long_base,
    input  logic              invert,
    output logic              pwm_out,
    output logic              conv_strobe
);

    localparam int LONG_IDX_W  = DATA_W - LONG_POS_W;
    localparam int SHORT_IDX_W = DATA_W - SHORT_POS_W;

    logic [DATA_W-1:0] cnt_next;
    logic              wrap;
    logic [DATA_W-1:0] data_next;
    logic              long_next;
    logic              inv_next;
    logic              act_long;
    logic              act_short;
    logic              slot_active;
    base_mode_e        mode_sel;
    logic              pwm_q;
    logic              strobe_q;

    dpwm_step_counter #(.CNT_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .cnt_next (cnt_next),
        .wrap     (wrap)
    );

    dpwm_data_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wrap),
        .data_in   (dac_data),
        .long_in   (long_base),
        .inv_in    (invert),
        .data_next (data_next),
        .long_next (long_next),
        .inv_next  (inv_next)
    );

    // 256-step base cycles: upper 8 bits basic, lower 6 bits additional.
    dpwm_slot_eval #(.POS_W(LONG_POS_W), .IDX_W(LONG_IDX_W)) u_eval_long (
        .pos    (cnt_next[LONG_POS_W-1:0]),
        .basic  (data_next[DATA_W-1:LONG_IDX_W]),
        .idx    (cnt_next[DATA_W-1:LONG_POS_W]),
        .add    (data_next[LONG_IDX_W-1:0]),
        .active (act_long)
    );

    // 64-step base cycles: upper 6 bits basic, lower 8 bits additional.
    dpwm_slot_eval #(.POS_W(SHORT_POS_W), .IDX_W(SHORT_IDX_W)) u_eval_short (
        .pos    (cnt_next[SHORT_POS_W-1:0]),
        .basic  (data_next[DATA_W-1:SHORT_IDX_W]),
        .idx    (cnt_next[DATA_W-1:SHORT_POS_W]),
        .add    (data_next[SHORT_IDX_W-1:0]),
        .active (act_short)
    );

    // Pick the evaluator that matches the sampled mode.
    always_comb begin
        mode_sel    = base_mode_e'(long_next);
        slot_active = (mode_sel == MODE_LONG_BASE) ? act_long : act_short;
    end

    // Output stage: polarity applied, boundary strobe registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            pwm_q    <= slot_active ^ inv_next;
            strobe_q <= wrap;
        end
    end

    assign pwm_out     = pwm_q;
    assign conv_strobe = strobe_q;

endmodule

// File: rtl/dpwm_dac_checker.sv
// Property checker for dpwm_dac, attached through bind.
// Assumes: connected to the top-level ports and the counter/latch wires.
module dpwm_dac_checker #(
    parameter int DATA_W     = 14,
    parameter int LONG_POS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              pwm_out,
    input logic              conv_strobe,
    input logic              wrap,
    input logic [DATA_W-1:0] cnt_next,
    input logic [DATA_W-1:0] data_next,
    input logic              long_next,
    input logic              inv_next
);

    // R1: strobe lasts one clock.
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |=> !conv_strobe);

    // R1: strobe only follows a step into position zero.
    p_strobe_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> ($past(cnt_next) == '0) && $past(step_en));

    // R2: no tick, no change at the output.
    p_hold_on_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pwm_out));

    // R3: a nonzero basic width makes step 0 of a long base cycle active.
    p_base_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (long_next && (cnt_next[LONG_POS_W-1:0] == '0) &&
         (data_next[DATA_W-1 -: LONG_POS_W] != '0))
        |=> (pwm_out != $past(inv_next)));

    // R8: sampled code holds between boundaries.
    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (wrap || $stable(data_next)));

    // R9: a zero code keeps the output at its idle level.
    p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_next == '0) && !inv_next) |=> !pwm_out);

    // R7: a zero code inverted keeps the output high.
    p_zero_inverted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_next == '0) && inv_next) |=> pwm_out);

endmodule

bind dpwm_dac dpwm_dac_checker #(
    .DATA_W     (DATA_W),
    .LONG_POS_W (LONG_POS_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .pwm_out     (pwm_out),
    .conv_strobe (conv_strobe),
    .wrap        (wrap),
    .cnt_next    (cnt_next),
    .data_next   (data_next),
    .long_next   (long_next),
    .inv_next    (inv_next)
);

// File: tb/dpwm_dac_bench.sv
// Scoreboard bench for dpwm_dac. A driver task queues the expected measurements
// for each conversion cycle; a monitor measures each cycle between strobes and
// compares the measurements with the queued item.
module dpwm_dac_bench;

    localparam int DW   = 14;
    localparam int CONV = 1 << DW;

    typedef struct {
        int    total;
        int    first;
        int    last;
        int    base_clk;
        int    period;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b1;
    logic [DW-1:0] dac_data = '0;
    logic          long_base = 1'b0;
    logic          invert = 1'b0;
    logic          pwm_out;
    logic          conv_strobe;

    exp_t sb_q[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    int   closed = 0;
    int   stride_req = 1;
    int   stride_cur = 1;
    int   phase = 0;
    bit   live = 1'b0;
    bit   started = 1'b0;
    int   idx = 0;
    int   hi_tot = 0;
    int   hi_first = 0;
    int   hi_last = 0;

    localparam int N_ITEMS = 7;

    dpwm_dac u_dpwm_dac (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .dac_data    (dac_data),
        .long_base   (long_base),
        .invert      (invert),
        .pwm_out     (pwm_out),
        .conv_strobe (conv_strobe)
    );

    always #2 clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver side: compute what one conversion cycle must look like.
    task automatic push_expect(logic [DW-1:0] d, bit lng, bit inv, int s, string tag);
        exp_t e;
        int   base;
        int   basic;
        int   add;
        int   w0;
        int   wl;
        base  = lng ? 256 : 64;
        basic = lng ? int'(d >> 6) : int'(d >> 8);
        add   = lng ? int'(d & 14'h003F) : int'(d & 14'h00FF);
        w0    = basic + ((add > 0) ? 1 : 0);
        wl    = basic;
        e.total    = inv ? (CONV - int'(d)) * s : int'(d) * s;
        e.first    = (inv ? base - w0 : w0) * s;
        e.last     = (inv ? base - wl : wl) * s;
        e.base_clk = base * s;
        e.period   = CONV * s;
        e.tag      = tag;
        sb_q.push_back(e);
    endtask

    task automatic next_boundary();
        @(negedge clk);
        while (!conv_strobe) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic apply(logic [DW-1:0] d, bit lng, bit inv, int s, string tag);
        dac_data   = d;
        long_base  = lng;
        invert     = inv;
        stride_req = s;
        push_expect(d, lng, inv, s, tag);
    endtask

    // Step tick generator; tick spacing changes only at a boundary.
    always @(negedge clk) begin
        if (conv_strobe) begin
            stride_cur = stride_req;
            phase      = 0;
        end
        step_en = (phase == stride_cur - 1);
        phase   = (phase + 1) % stride_cur;
    end

    function automatic void open_item();
        if (sb_q.size() > 0) begin
            cur  = sb_q.pop_front();
            live = 1'b1;
        end else begin
            live = 1'b0;
        end
        idx      = 0;
        hi_tot   = 0;
        hi_first = 0;
        hi_last  = 0;
    endfunction

    task automatic close_item();
        if (live) begin
            check({cur.tag, " R1 conversion period in clocks"}, idx, cur.period);
            check({cur.tag, " R6 R8 active clocks per conversion"}, hi_tot, cur.total);
            check({cur.tag, " R5 first base cycle high clocks"}, hi_first, cur.first);
            check({cur.tag, " last base cycle high clocks"}, hi_last, cur.last);
            closed++;
        end
    endtask

    // Monitor: measure each conversion cycle between strobes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!started) begin
                started = 1'b1;
                check("R9 pwm_out low after reset", int'(pwm_out), 0);
                check("R1 R9 no strobe after reset", int'(conv_strobe), 0);
                open_item();
            end else if (conv_strobe) begin
                close_item();
                open_item();
            end
            if (live) begin
                if (pwm_out) begin
                    hi_tot++;
                    if (idx < cur.base_clk) hi_first++;
                    if (idx >= cur.period - cur.base_clk) hi_last++;
                end
                idx++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired after %0d checks", checks);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        dac_data  = 14'h0207;
        long_base = 1'b1;
        invert    = 1'b0;
        push_expect(14'h0000, 1'b0, 1'b0, 1, "R9 idle after reset");
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        push_expect(14'h0207, 1'b1, 1'b0, 1, "R3 long 0x0207");
        next_boundary();
        apply(14'h1234, 1'b0, 1'b0, 1, "R4 short 0x1234");
        next_boundary();
        apply(14'h0207, 1'b1, 1'b1, 1, "R7 inverted 0x0207");
        next_boundary();
        apply(14'h3FFF, 1'b1, 1'b0, 1, "R3 full scale");
        next_boundary();
        apply(14'h00FF, 1'b0, 1'b0, 1, "R5 short additional only");
        next_boundary();
        apply(14'h2001, 1'b0, 1'b0, 2, "R2 half-rate ticks");
        wait (closed == N_ITEMS);
        @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule